// File: doc/BRIEF.md
# Timekeeping Counter with Alarm Match

This block holds the time of day as six BCD digits (hours, minutes, seconds) and advances it by one second whenever a one-cycle seconds enable arrives. A settings menu upstream supplies a mode code and a pair of digits. A separate write strobe copies that pair into the hour, minute or second field picked by the mode code. Cycling through the menu with the strobe low never disturbs the running time. Digit pairs that are not legal for the addressed field are dropped.

An arming toggle input switches the alarm on and off, and a steady LED reports the armed state. The alarm time arrives as a packed 24-bit BCD word. While the alarm is armed, the block starts ringing as soon as the running time equals that word. Ringing flashes a second LED, which toggles on each half-second enable. The ringing stops after a parameterised number of seconds, or at once when the alarm is disarmed.

Top module: `alarm_clock_core`

## Requirements
- R1: After reset all six time digits are 0 and both the armed LED and the alarm LED are off.
- R2: Each cycle with `sec_tick` high advances the time by one second; with neither `sec_tick` nor `load_stb` high the digits hold.
- R3: Seconds wrap 59 to 00 carrying into minutes, minutes wrap 59 to 00 carrying into hours, hours wrap 23 to 00; no field ever leaves its range.
- R4: With `load_stb` high, mode code 1 loads hours, 2 loads minutes and 3 loads seconds from `set_tens`/`set_units` at the next edge; the other fields are unchanged.
- R5: With `load_stb` low, or with any mode code other than 1, 2 or 3, the set digits are ignored.
- R6: A load whose units digit exceeds 9, or whose value exceeds 23 for hours or 59 for minutes and seconds, is ignored.
- R7: When a load and `sec_tick` meet in one cycle, the loaded field takes the set value without increment and passes no carry upward; fields below it still advance.
- R8: Each cycle with `arm_toggle` high flips the armed state, shown on `armed_led` from the next edge.
- R9: While armed, the clock edge after the digits first equal `alarm_time` (bits 23:20 hour tens, 19:16 hour units, 15:12 minute tens, 11:8 minute units, 7:4 second tens, 3:0 second units) starts ringing, with `alarm_led` lit.
- R10: While ringing, `alarm_led` toggles on each cycle with `blink_tick` high.
- R11: Ringing ends at the edge of the RING_SECS-th `sec_tick` after it began (default 60), turning `alarm_led` off.
- R12: Disarming while ringing turns `alarm_led` off at the same edge that clears `armed_led`.
- R13: While disarmed, a time match never lights `alarm_led`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle enable, once per second |
| blink_tick | input | 1 | One-cycle enable, once per half second |
| mode | input | 3 | Menu mode code selecting the field to load |
| load_stb | input | 1 | Write strobe for the selected field |
| set_tens | input | 4 | Tens digit to load |
| set_units | input | 4 | Units digit to load |
| arm_toggle | input | 1 | Pulse that flips the armed state |
| alarm_time | input | 24 | Alarm time as packed BCD HHMMSS |
| hr_tens | output | 4 | Hour tens digit |
| hr_units | output | 4 | Hour units digit |
| min_tens | output | 4 | Minute tens digit |
| min_units | output | 4 | Minute units digit |
| sec_tens | output | 4 | Second tens digit |
| sec_units | output | 4 | Second units digit |
| armed_led | output | 1 | High while the alarm is armed |
| alarm_led | output | 1 | Flashing indicator while ringing |

## Verification
The digits leave the block straight from their registers, so a corrupted field or a lost carry shows on the very next edge after the tick or load that caused it. A stuck ring counter or a missed match shows on `alarm_led` one edge after the matching tick, or fails to darken it on the edge of the final ringing second. A phase register that is set wrong on entry shows as an LED that stays dark on the first cycle of ringing.

// File: rtl/alarm_clock_pkg.sv
package alarm_clock_pkg;

  localparam int DIGIT_W = 4;

  typedef logic [DIGIT_W-1:0] bcd_t;

  localparam logic [2:0] MODE_SET_HR  = 3'd1;
  localparam logic [2:0] MODE_SET_MIN = 3'd2;
  localparam logic [2:0] MODE_SET_SEC = 3'd3;

  // Numeric value of a BCD pair.
  function automatic int pair_value(bcd_t t, bcd_t u);
    return int'(t) * 10 + int'(u);
  endfunction

  // A pair is loadable when both digits are decimal and it fits the field.
  function automatic logic pair_legal(bcd_t t, bcd_t u, int max_val);
    return (t <= 4'd9) && (u <= 4'd9) && (pair_value(t, u) <= max_val);
  endfunction

  // Next pair in the counting sequence, wrapping to 00 after max_val.
  function automatic logic [2*DIGIT_W-1:0] pair_next(bcd_t t, bcd_t u, int max_val);
    if (pair_value(t, u) >= max_val) return '0;
    if (u == 4'd9) return {t + 4'd1, 4'd0};
    return {t, u + 4'd1};
  endfunction

endpackage

// File: rtl/bcd_field.sv
module bcd_field
  import alarm_clock_pkg::*;
#(
  parameter int MAX_VAL = 59
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  input  logic load_i,
  input  bcd_t set_tens_i,
  input  bcd_t set_units_i,
  output bcd_t tens_o,
  output bcd_t units_o,
  output logic carry_o
);

  bcd_t tens_q, units_q;
  logic load_ok;
  logic at_max;

  assign load_ok = load_i && pair_legal(set_tens_i, set_units_i, MAX_VAL);
  assign at_max  = (pair_value(tens_q, units_q) == MAX_VAL);
  assign carry_o = adv_i && !load_ok && at_max;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tens_q  <= '0;
      units_q <= '0;
    end else if (load_ok) begin
      tens_q  <= set_tens_i;
      units_q <= set_units_i;
    end else if (adv_i) begin
      {tens_q, units_q} <= pair_next(tens_q, units_q, MAX_VAL);
    end
  end

  assign tens_o  = tens_q;
  assign units_o = units_q;

endmodule

// File: rtl/alarm_ring.sv
module alarm_ring #(
  parameter int RING_SECS = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_toggle_i,
  input  logic match_i,
  input  logic sec_tick_i,
  input  logic blink_tick_i,
  output logic armed_o,
  output logic ringing_o,
  output logic led_o
);

  localparam int CW = $clog2(RING_SECS + 1);
  localparam logic [CW-1:0] LAST = CW'(RING_SECS - 1);

  logic          armed_q, ring_q, phase_q;
  logic [CW-1:0] secs_q;
  logic          ring_start, ring_stop;

  assign ring_start = armed_q && !arm_toggle_i && match_i && !ring_q;
  assign ring_stop  = ring_q && ((arm_toggle_i && armed_q) ||
                                 (sec_tick_i && secs_q == LAST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      ring_q  <= 1'b0;
      phase_q <= 1'b0;
      secs_q  <= '0;
    end else begin
      if (arm_toggle_i) armed_q <= !armed_q;
      if (ring_start) begin
        ring_q  <= 1'b1;
        phase_q <= 1'b1;
        secs_q  <= '0;
      end else if (ring_stop) begin
        ring_q  <= 1'b0;
        phase_q <= 1'b0;
      end else if (ring_q) begin
        if (blink_tick_i) phase_q <= !phase_q;
        if (sec_tick_i)   secs_q  <= secs_q + 1'b1;
      end
    end
  end

  assign armed_o   = armed_q;
  assign ringing_o = ring_q;
  assign led_o     = ring_q && phase_q;

endmodule

// File: rtl/alarm_clock_core.sv
module alarm_clock_core
  import alarm_clock_pkg::*;
#(
  parameter int RING_SECS = 60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sec_tick,
  input  logic        blink_tick,
  input  logic [2:0]  mode,
  input  logic        load_stb,
  input  logic [3:0]  set_tens,
  input  logic [3:0]  set_units,
  input  logic        arm_toggle,
  input  logic [23:0] alarm_time,
  output logic [3:0]  hr_tens,
  output logic [3:0]  hr_units,
  output logic [3:0]  min_tens,
  output logic [3:0]  min_units,
  output logic [3:0]  sec_tens,
  output logic [3:0]  sec_units,
  output logic        armed_led,
  output logic        alarm_led
);

  localparam int NFIELD = 3;

  // Field 0 = seconds, 1 = minutes, 2 = hours.
  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    localparam int MAXV = (i == NFIELD - 1) ? 23 : 59;
    localparam logic [2:0] MY_MODE = 3'(NFIELD - i);
    logic adv, carry;
    bcd_t tens, units;
    if (i == 0) begin : g_first
      assign adv = sec_tick;
    end else begin : g_chain
      assign adv = g_field[i-1].carry;
    end
    bcd_field #(.MAX_VAL(MAXV)) u_field (
      .clk         (clk),
      .rst_n       (rst_n),
      .adv_i       (adv),
      .load_i      (load_stb && (mode == MY_MODE)),
      .set_tens_i  (set_tens),
      .set_units_i (set_units),
      .tens_o      (tens),
      .units_o     (units),
      .carry_o     (carry)
    );
  end

  assign sec_tens  = g_field[0].tens;
  assign sec_units = g_field[0].units;
  assign min_tens  = g_field[1].tens;
  assign min_units = g_field[1].units;
  assign hr_tens   = g_field[2].tens;
  assign hr_units  = g_field[2].units;

  // Named internal events for the checker.
  logic [23:0] now_bcd;
  logic        time_match;
  logic        ring_active;
  logic        sec_carry, min_carry;

  assign now_bcd    = {hr_tens, hr_units, min_tens, min_units, sec_tens, sec_units};
  assign time_match = (now_bcd == alarm_time);
  assign sec_carry  = g_field[0].carry;
  assign min_carry  = g_field[1].carry;

  alarm_ring #(.RING_SECS(RING_SECS)) u_ring (
    .clk          (clk),
    .rst_n        (rst_n),
    .arm_toggle_i (arm_toggle),
    .match_i      (time_match),
    .sec_tick_i   (sec_tick),
    .blink_tick_i (blink_tick),
    .armed_o      (armed_led),
    .ringing_o    (ring_active),
    .led_o        (alarm_led)
  );

endmodule

// File: rtl/alarm_clock_checker.sv
module alarm_clock_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        sec_tick,
  input logic [2:0]  mode,
  input logic        load_stb,
  input logic [3:0]  set_tens,
  input logic [3:0]  set_units,
  input logic        arm_toggle,
  input logic [23:0] now_bcd,
  input logic        armed_led,
  input logic        alarm_led,
  input logic        ring_active,
  input logic        time_match
);

  AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    now_bcd[7:4] <= 4'd5 && now_bcd[3:0] <= 4'd9);  // R3

  AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    now_bcd[23:16] <= 8'h23 && now_bcd[19:16] <= 4'd9);  // R3

  AST_DAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick && !load_stb && now_bcd == 24'h235959 |=> now_bcd == 24'h000000);  // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick && !load_stb |=> $stable(now_bcd));  // R2

  AST_HOUR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb && mode == 3'd1 && set_units <= 4'd9 && {set_tens, set_units} <= 8'h23
    |=> now_bcd[23:16] == $past({set_tens, set_units}));  // R4

  AST_ARM_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    arm_toggle |=> armed_led != $past(armed_led));  // R8

  AST_RING_START: assert property (@(posedge clk) disable iff (!rst_n)
    armed_led && time_match && !ring_active && !arm_toggle |=> alarm_led);  // R9

  AST_QUIET_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_led |-> !alarm_led);  // R13

endmodule

bind alarm_clock_core alarm_clock_checker i_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .sec_tick    (sec_tick),
  .mode        (mode),
  .load_stb    (load_stb),
  .set_tens    (set_tens),
  .set_units   (set_units),
  .arm_toggle  (arm_toggle),
  .now_bcd     (now_bcd),
  .armed_led   (armed_led),
  .alarm_led   (alarm_led),
  .ring_active (ring_active),
  .time_match  (time_match)
);

// File: tb/test_alarm_clock_core.sv
module test_alarm_clock_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick = 1'b0;
  logic        blink_tick = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic        load_stb = 1'b0;
  logic [3:0]  set_tens = 4'd0;
  logic [3:0]  set_units = 4'd0;
  logic        arm_toggle = 1'b0;
  logic [23:0] alarm_time = 24'h999999;
  logic [3:0]  hr_tens, hr_units, min_tens, min_units, sec_tens, sec_units;
  logic        armed_led, alarm_led;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alarm_clock_core i_alarm_clock_core (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .blink_tick(blink_tick),
    .mode(mode), .load_stb(load_stb), .set_tens(set_tens), .set_units(set_units),
    .arm_toggle(arm_toggle), .alarm_time(alarm_time),
    .hr_tens(hr_tens), .hr_units(hr_units), .min_tens(min_tens),
    .min_units(min_units), .sec_tens(sec_tens), .sec_units(sec_units),
    .armed_led(armed_led), .alarm_led(alarm_led)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int shown();
    return hr_tens * 100000 + hr_units * 10000 + min_tens * 1000 +
           min_units * 100 + sec_tens * 10 + sec_units;
  endfunction

  // Expected display computed from seconds of the day.
  task automatic check_time(string req, int sod);
    int s = sod % 86400;
    check(req, "time hhmmss", shown(), (s / 3600) * 10000 + ((s / 60) % 60) * 100 + s % 60);
  endtask

  task automatic tick();
    @(negedge clk) sec_tick = 1'b1;
    @(negedge clk) sec_tick = 1'b0;
  endtask

  task automatic blink();
    @(negedge clk) blink_tick = 1'b1;
    @(negedge clk) blink_tick = 1'b0;
  endtask

  task automatic toggle_arm();
    @(negedge clk) arm_toggle = 1'b1;
    @(negedge clk) arm_toggle = 1'b0;
  endtask

  task automatic load(int m, int t, int u);
    @(negedge clk);
    mode = 3'(m); set_tens = 4'(t); set_units = 4'(u); load_stb = 1'b1;
    @(negedge clk);
    load_stb = 1'b0; mode = 3'd0;
  endtask

  task automatic set_time(int h, int mi, int s);
    load(3, s / 10, s % 10);
    load(2, mi / 10, mi % 10);
    load(1, h / 10, h % 10);
  endtask

  function automatic int sod(int h, int mi, int s);
    return h * 3600 + mi * 60 + s;
  endfunction

  task automatic t_reset();
    check_time("R1", 0);
    check("R1", "armed_led", int'(armed_led), 0);
    check("R1", "alarm_led", int'(alarm_led), 0);
  endtask

  task automatic t_count();
    for (int i = 0; i < 3; i++) tick();
    check_time("R2", 3);
    repeat (5) @(negedge clk);
    check_time("R2", 3);
  endtask

  task automatic t_load();
    set_time(12, 34, 56);
    check_time("R4", sod(12, 34, 56));
    load(2, 0, 7);
    check_time("R4", sod(12, 7, 56));
    load(0, 0, 1);
    check_time("R5", sod(12, 7, 56));
    load(5, 0, 1);
    check_time("R5", sod(12, 7, 56));
    @(negedge clk) mode = 3'd1; set_tens = 4'd0; set_units = 4'd3;
    @(negedge clk) mode = 3'd0;
    check_time("R5", sod(12, 7, 56));
  endtask

  task automatic t_illegal();
    load(1, 2, 4);
    check_time("R6", sod(12, 7, 56));
    load(2, 6, 0);
    check_time("R6", sod(12, 7, 56));
    load(3, 3, 10);
    check_time("R6", sod(12, 7, 56));
    load(1, 2, 3);
    check_time("R6", sod(23, 7, 56));
  endtask

  task automatic t_wrap();
    set_time(12, 34, 59);
    tick();
    check_time("R3", sod(12, 35, 0));
    set_time(12, 59, 59);
    tick();
    check_time("R3", sod(13, 0, 0));
    set_time(23, 59, 59);
    tick();
    check_time("R3", 0);
  endtask

  task automatic t_collide();
    set_time(10, 20, 59);
    @(negedge clk);
    mode = 3'd2; set_tens = 4'd4; set_units = 4'd5; load_stb = 1'b1; sec_tick = 1'b1;
    @(negedge clk);
    load_stb = 1'b0; sec_tick = 1'b0; mode = 3'd0;
    check_time("R7", sod(10, 45, 0));
    @(negedge clk);
    mode = 3'd3; set_tens = 4'd3; set_units = 4'd0; load_stb = 1'b1; sec_tick = 1'b1;
    @(negedge clk);
    load_stb = 1'b0; sec_tick = 1'b0; mode = 3'd0;
    check_time("R7", sod(10, 45, 30));
  endtask

  task automatic t_arm();
    toggle_arm();
    check("R8", "armed after first toggle", int'(armed_led), 1);
    toggle_arm();
    check("R8", "armed after second toggle", int'(armed_led), 0);
  endtask

  task automatic t_ring();
    set_time(7, 30, 4);
    alarm_time = 24'h073005;
    toggle_arm();
    check("R13", "no ring before match", int'(alarm_led), 0);
    tick();
    check("R9", "led same edge as match", int'(alarm_led), 0);
    @(negedge clk);
    check("R9", "led edge after match", int'(alarm_led), 1);
    blink();
    check("R10", "led after one blink", int'(alarm_led), 0);
    blink();
    check("R10", "led after two blinks", int'(alarm_led), 1);
    for (int i = 0; i < 59; i++) tick();
    check("R11", "still ringing after 59 s", int'(alarm_led), 1);
    tick();
    check("R11", "ring ended after 60 s", int'(alarm_led), 0);
    repeat (3) @(negedge clk);
    check("R11", "stays off", int'(alarm_led), 0);
    check_time("R2", sod(7, 31, 5));
  endtask

  task automatic t_disarm();
    alarm_time = 24'h073107;
    tick();
    tick();
    @(negedge clk);
    check("R9", "second ring started", int'(alarm_led), 1);
    toggle_arm();
    check("R12", "led off on disarm", int'(alarm_led), 0);
    check("R12", "armed off", int'(armed_led), 0);
    alarm_time = 24'h073108;
    tick();
    repeat (2) @(negedge clk);
    check("R13", "disarmed match quiet", int'(alarm_led), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_load();
    t_illegal();
    t_wrap();
    t_collide();
    t_arm();
    t_ring();
    t_disarm();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule